// File: doc/BRIEF.md
# Fetch-Stage Relative Branch Unit

This block sits in the fetch stage of a three-stage pipeline (fetch, decode, execute with memory access) and chooses the address of the next word to fetch from a word-addressed program memory. It owns the program counter register. Each cycle it looks at the 16-bit instruction fetched at the current PC. It redirects in that same cycle for relative jumps, relative calls, branches on the zero or carry flag, and jumps to an address held in a register.

Relative targets are formed by adding a signed 11-bit word offset to the address of the branch instruction itself. A relative call also asks the register file to write the address of the following word into register 15. Any redirect raises a flush so that the instruction now in decode is discarded. The flags come from the instruction most recently finished in execute. A stall freezes the PC and suppresses every side effect.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 (parameter `RESET_PC`).
- R2: For any instruction that is not a redirect and with `stall_i` low, the PC advances by one word modulo 2^PC_W, and `flush_o` and `link_we_o` stay low.
- R3: Opcode bits [15:11] = 11000 always redirects to PC + sign-extended instr[10:0].
- R4: Opcode 11001 redirects like R3. In the same cycle it raises `link_we_o`, with `link_pc_o` = PC + 1 and `link_reg_o` = 15.
- R5: Opcode 11010 redirects only when the zero flag is 0. Opcode 11011 redirects only when the zero flag is 1. When the branch is not taken, R2 applies.
- R6: Opcode 11100 redirects only when the carry flag is 0. Opcode 11101 redirects only when the carry flag is 1. When the branch is not taken, R2 applies.
- R7: An instruction whose bits [15:4] equal 0xFF0 loads the PC with `jreg_i`, and `jreg_idx_o` equals instr[3:0]. Neighbouring codes such as 0xFF1x and 0xFEFx are not redirects.
- R8: `flush_o` is high in exactly the cycles in which a redirect is taken, and `npc_o` shows the address loaded at the next clock edge.
- R9: With `stall_i` high, the PC holds, `npc_o` equals `pc_o`, and `flush_o` and `link_we_o` are low, whatever the instruction and flags.
- R10: Relative targets wrap modulo 2^PC_W. The offsets -1024 and +1023 reach exactly PC-1024 and PC+1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold the PC and suppress redirects |
| instr_i | input | INSTR_W | Instruction fetched at `pc_o` |
| flag_z_i | input | 1 | Zero flag from the last executed instruction |
| flag_c_i | input | 1 | Carry flag from the last executed instruction |
| jreg_i | input | PC_W | Register value for the absolute jump |
| jreg_idx_o | output | 4 | Register index read for the absolute jump |
| pc_o | output | PC_W | Current fetch address |
| npc_o | output | PC_W | Address to be fetched next |
| link_we_o | output | 1 | Write request for the link register |
| link_reg_o | output | 4 | Index of the link register (15) |
| link_pc_o | output | PC_W | Return address to be written |
| flush_o | output | 1 | Discard the instruction in decode |

## Verification
Two of this block's actions can land in the same cycle: a redirect and a stall, and a redirect and a link write. Every branch opcode is replayed with `stall_i` high and all flag combinations. The bench expects the stall to win: the PC holds, and neither flush nor link appears. Every relative call is checked for a link write that carries PC+1 at the same moment as its flush and new target. The bench predicts these values from its own arithmetic over many start addresses and edge offsets.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

    typedef enum logic [2:0] {
        K_SEQ,
        K_RJMP,
        K_RCALL,
        K_BNE,
        K_BEQ,
        K_BCC,
        K_BCS,
        K_AJMP
    } kind_e;

    localparam logic [4:0]  OP_RJMP  = 5'b11000;
    localparam logic [4:0]  OP_RCALL = 5'b11001;
    localparam logic [4:0]  OP_BNE   = 5'b11010;
    localparam logic [4:0]  OP_BEQ   = 5'b11011;
    localparam logic [4:0]  OP_BCC   = 5'b11100;
    localparam logic [4:0]  OP_BCS   = 5'b11101;
    localparam logic [11:0] AJMP_HI  = 12'hFF0;

endpackage

// File: rtl/rbu_decode.sv
module rbu_decode
    import rbu_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int OFF_W   = 11
) (
    input  logic [INSTR_W-1:0] instr_i,
    output kind_e              kind_o,
    output logic [OFF_W-1:0]   off_o,
    output logic [3:0]         ridx_o
);

    localparam int OPC_LSB = INSTR_W - 5;

    logic [4:0] opc;

    assign opc    = instr_i[INSTR_W-1:OPC_LSB];
    assign off_o  = instr_i[OFF_W-1:0];
    assign ridx_o = instr_i[3:0];

    always_comb begin
        case (opc)
            OP_RJMP:  kind_o = K_RJMP;
            OP_RCALL: kind_o = K_RCALL;
            OP_BNE:   kind_o = K_BNE;
            OP_BEQ:   kind_o = K_BEQ;
            OP_BCC:   kind_o = K_BCC;
            OP_BCS:   kind_o = K_BCS;
            default:  kind_o = (instr_i[INSTR_W-1:4] == AJMP_HI) ? K_AJMP : K_SEQ;
        endcase
    end

endmodule

// File: rtl/rbu_cond.sv
module rbu_cond
    import rbu_pkg::*;
(
    input  kind_e kind_i,
    input  logic  z_i,
    input  logic  c_i,
    output logic  take_o,
    output logic  abs_o,
    output logic  link_o
);

    always_comb begin
        take_o = 1'b0;
        abs_o  = 1'b0;
        link_o = 1'b0;
        case (kind_i)
            K_RJMP:  take_o = 1'b1;
            K_RCALL: begin
                take_o = 1'b1;
                link_o = 1'b1;
            end
            K_BNE:   take_o = ~z_i;
            K_BEQ:   take_o = z_i;
            K_BCC:   take_o = ~c_i;
            K_BCS:   take_o = c_i;
            K_AJMP:  begin
                take_o = 1'b1;
                abs_o  = 1'b1;
            end
            default: take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
    import rbu_pkg::*;
#(
    parameter int          INSTR_W  = 16,
    parameter int          OFF_W    = 11,
    parameter int          PC_W     = 16,
    parameter int          LINK_REG = 15,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    input  logic [PC_W-1:0]    jreg_i,
    output logic [3:0]         jreg_idx_o,
    output logic [PC_W-1:0]    pc_o,
    output logic [PC_W-1:0]    npc_o,
    output logic               link_we_o,
    output logic [3:0]         link_reg_o,
    output logic [PC_W-1:0]    link_pc_o,
    output logic               flush_o
);

    localparam int            EXT_W = PC_W - OFF_W;
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            link_we;
        logic [PC_W-1:0] link_pc;
        logic            flush;
    } step_t;

    kind_e            kind;
    logic [OFF_W-1:0] off;
    logic             take, is_abs, is_link;
    logic [PC_W-1:0]  off_ext;
    logic [PC_W-1:0]  pc_q;
    step_t            st_d;

    rbu_decode #(.INSTR_W(INSTR_W), .OFF_W(OFF_W)) u_dec (
        .instr_i (instr_i),
        .kind_o  (kind),
        .off_o   (off),
        .ridx_o  (jreg_idx_o)
    );

    rbu_cond u_cond (
        .kind_i (kind),
        .z_i    (flag_z_i),
        .c_i    (flag_c_i),
        .take_o (take),
        .abs_o  (is_abs),
        .link_o (is_link)
    );

    generate
        if (EXT_W > 0) begin : g_sext
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d.pc      = pc_q + ONE;
        st_d.link_we = 1'b0;
        st_d.link_pc = pc_q + ONE;
        st_d.flush   = 1'b0;
        if (stall_i) begin
            st_d.pc = pc_q;
        end else if (take) begin
            st_d.pc      = is_abs ? jreg_i : (pc_q + off_ext);
            st_d.flush   = 1'b1;
            st_d.link_we = is_link;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_PC[PC_W-1:0];
        else        pc_q <= st_d.pc;
    end

    assign pc_o       = pc_q;
    assign npc_o      = st_d.pc;
    assign link_we_o  = st_d.link_we;
    assign link_pc_o  = st_d.link_pc;
    assign flush_o    = st_d.flush;
    assign link_reg_o = 4'(LINK_REG);

    // Assertions

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> pc_o == $past(pc_o));

    assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (!flush_o && !link_we_o));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !flush_o) |=> pc_o == $past(pc_o) + ONE);

    assert_redirect_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> pc_o == $past(npc_o));

    assert_link_with_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (flush_o && link_pc_o == pc_o + ONE
                       && instr_i[INSTR_W-1:INSTR_W-5] == OP_RCALL));

    assert_carry_set_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && instr_i[INSTR_W-1:INSTR_W-5] == OP_BCS) |-> flush_o == flag_c_i);

    assert_zero_set_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && instr_i[INSTR_W-1:INSTR_W-5] == OP_BEQ) |-> flush_o == flag_z_i);

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |-> pc_o == RESET_PC[PC_W-1:0]);

endmodule

// File: tb/sim_rel_branch_unit.sv
module sim_rel_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [15:0] instr = 16'hFFFF;
    logic        fz = 1'b0, fc = 1'b0;
    logic [15:0] jreg = 16'h0;
    logic [3:0]  jidx;
    logic [15:0] pc, npc, lpc;
    logic        lwe, flush;
    logic [3:0]  lreg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rel_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .stall_i(stall), .instr_i(instr),
        .flag_z_i(fz), .flag_c_i(fc), .jreg_i(jreg), .jreg_idx_o(jidx),
        .pc_o(pc), .npc_o(npc), .link_we_o(lwe), .link_reg_o(lreg),
        .link_pc_o(lpc), .flush_o(flush)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One fetch cycle: drive, check combinational outputs, check PC after edge.
    task automatic step(input logic [15:0] ins, input logic z, input logic c,
                        input logic [15:0] jr, input logic st);
        logic [15:0] p, tgt, enp;
        logic        tk, lk, ab;
        string       tag;
        @(negedge clk);
        instr = ins; fz = z; fc = c; jreg = jr; stall = st;
        #1;
        p   = pc;
        tgt = p + {{5{ins[10]}}, ins[10:0]};
        tk = 1'b0; lk = 1'b0; ab = 1'b0; tag = "R2";
        case (ins[15:11])
            5'b11000: begin tk = 1'b1; tag = "R3"; end
            5'b11001: begin tk = 1'b1; lk = 1'b1; tag = "R4"; end
            5'b11010: begin tk = !z; tag = "R5"; end
            5'b11011: begin tk = z;  tag = "R5"; end
            5'b11100: begin tk = !c; tag = "R6"; end
            5'b11101: begin tk = c;  tag = "R6"; end
            default: if (ins[15:4] == 12'hFF0) begin tk = 1'b1; ab = 1'b1; tag = "R7"; end
        endcase
        if (st) begin
            tk = 1'b0; lk = 1'b0; tag = "R9";
        end
        enp = st ? p : (tk ? (ab ? jr : tgt) : p + 16'd1);
        chk(npc == enp, {tag, " npc"}, 32'(npc), 32'(enp));
        chk(flush == tk, {tag, " R8 flush"}, 32'(flush), 32'(tk));
        chk(lwe == lk, {tag, " link_we"}, 32'(lwe), 32'(lk));
        if (lk) begin
            chk(lpc == p + 16'd1, "R4 link_pc", 32'(lpc), 32'(p + 16'd1));
            chk(lreg == 4'd15, "R4 link_reg", 32'(lreg), 32'd15);
        end
        if (ab) chk(jidx == ins[3:0], "R7 jreg_idx", 32'(jidx), 32'(ins[3:0]));
        @(posedge clk);
        #1;
        chk(pc == enp, {tag, " pc"}, 32'(pc), 32'(enp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [15:0] starts [5];
        logic [10:0] offs [7];
        starts = '{16'h0000, 16'h0005, 16'hFFFF, 16'h8000, 16'h03E8};
        offs   = '{11'h000, 11'h001, 11'h7FF, 11'h3FF, 11'h400, 11'h12C, 11'h7F9};

        repeat (3) @(negedge clk);
        chk(pc == 16'h0, "R1 reset pc", 32'(pc), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(pc == 16'h0, "R1 pc after release", 32'(pc), 32'h0);

        // R3..R6, R10: all branch opcodes, flags, start addresses and edge offsets
        for (int s = 0; s < 5; s++)
            for (int o = 0; o < 7; o++)
                for (int op = 24; op < 30; op++)
                    for (int f = 0; f < 4; f++) begin
                        step(16'hFF00, 1'b0, 1'b0, starts[s], 1'b0);
                        step({op[4:0], offs[o]}, f[0], f[1], 16'h0, 1'b0);
                    end

        // R10: explicit extremes from a mid address
        step(16'hFF00, 1'b0, 1'b0, 16'h1000, 1'b0);
        step({5'b11000, 11'h400}, 1'b0, 1'b0, 16'h0, 1'b0);
        chk(pc == 16'h0C00, "R10 min offset", 32'(pc), 32'h0C00);
        step(16'hFF00, 1'b0, 1'b0, 16'h1000, 1'b0);
        step({5'b11000, 11'h3FF}, 1'b0, 1'b0, 16'h0, 1'b0);
        chk(pc == 16'h13FF, "R10 max offset", 32'(pc), 32'h13FF);

        // R2: every other top opcode with varied low bits
        for (int h = 0; h < 32; h++)
            if (h < 24 || h > 29)
                for (int f = 0; f < 4; f++)
                    step({h[4:0], 11'h2A7 ^ 11'(h * 37)}, f[0], f[1], 16'hBEEF, 1'b0);

        // R7: absolute jump for each index, and near-miss codes
        for (int x = 0; x < 16; x++)
            step({12'hFF0, x[3:0]}, 1'b0, 1'b0, 16'(x * 4099 + 7), 1'b0);
        step(16'hFF13, 1'b1, 1'b1, 16'h1234, 1'b0);
        step(16'hFEF0, 1'b0, 1'b1, 16'h1234, 1'b0);
        step(16'hFF20, 1'b1, 1'b0, 16'h1234, 1'b0);

        // R9: stall against every redirect kind and flag combination
        step(16'hFF00, 1'b0, 1'b0, 16'h4242, 1'b0);
        for (int op = 24; op < 30; op++)
            for (int f = 0; f < 4; f++)
                step({op[4:0], 11'h155}, f[0], f[1], 16'h0, 1'b1);
        step(16'hFF05, 1'b0, 1'b0, 16'h9999, 1'b1);
        step(16'h0000, 1'b0, 1'b0, 16'h0, 1'b1);
        chk(pc == 16'h4242, "R9 pc held", 32'(pc), 32'h4242);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(pc == 16'h0, "R1 async reset", 32'(pc), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

endmodule